// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block counts scanlines for one display pipe. With variable refresh turned on, the frame length is not fixed. The counter holds the pipe in vertical blanking until software requests a push. It then runs a blanking exit sequence of known length and wraps to the first line of the next frame. The frame length always lands between a programmable minimum (the flip line) and a programmable maximum. With variable refresh turned off, the counter produces frames of fixed length.

The counter advances on a one-cycle line strobe. A small write port programs the timing registers and the push register. The timing registers are double-buffered. Writes go to an armed copy, and the copy that governs timing takes the armed values on the register-latch strobe. That strobe fires when the blanking exit starts (variable mode) or on the first blanking line (fixed mode). Frame-start marks the cycle in which the counter returns to line 0.

Top module: `vrr_vtiming`

## Requirements
- R1: After reset the line output is 0, frame-start, register-latch and push-pending are low, and the block runs in fixed mode with a 30-line frame whose blanking starts at line 20.
- R2: The vblank output is high exactly when the current line is at or above the active-lines value (address 0) that governs the current frame.
- R3: When a push is pending before the earliest exit line (flip line minus exit length), the exit starts at that earliest line, so the frame lasts exactly the flip line count (address 3 value plus one).
- R4: With no push, the exit starts at the vmax boundary (address 2 value plus one, minus exit length), so the frame lasts exactly vmax lines and never more.
- R5: A push written during line k inside the exit window starts the exit at line k+1. The register-latch strobe pulses for one cycle as the counter enters that line, and the frame lasts k+1 plus the exit length.
- R6: The push register (address 5) has bit 0 as push enable and bit 1 as send. A write with both bits set makes push-pending read 1, and push-pending returns to 0 when the exit starts.
- R7: With control bit 0 clear, the frame lasts the address 1 value plus one lines, and the register-latch strobe fires as the counter enters the active-lines line.
- R8: A push write with bit 0 clear leaves push-pending at 0, and the frame then runs to vmax.
- R9: With control bit 1 (flip-line enable) clear, the flip line is taken as the minimum frame (address 1 value plus one) plus one.
- R10: Timing registers (0 active lines, 1 vmin-1, 2 vmax-1, 3 flip-1, 4 control) written mid-frame do not affect that frame's decisions. They take effect at the next register-latch strobe.
- R11: The exit length is guardband (control bits 11:4) plus frame-start delay (control bits 3:2 plus one) plus one line.
- R12: Frame-start is a one-cycle pulse in the cycle the line output becomes 0, and it never coincides with the register-latch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle strobe per scanline |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| line | output | 12 | Current scanline |
| vblank | output | 1 | Vertical blanking active |
| frame_start | output | 1 | Pulse as the counter returns to line 0 |
| reg_latch | output | 1 | Pulse when double-buffered registers update |
| push_pending | output | 1 | Push request not yet consumed |

## Verification
The assertions assume a consistent register set: active lines at least 1, the earliest exit line at or after the start of blanking, a flip line no larger than vmax, and a vmax that does not shrink below a line the counter has already passed. They also assume that line strobes are single-cycle pulses with idle cycles between them. The stimulus applies whole configurations only through the double-buffered path. It shortens vmax only while the counter is still below the new value, spaces line strobes four clocks apart, and places every write in the cycles between strobes.

// File: rtl/vrr_pkg.sv
`timescale 1ns/1ps
package vrr_pkg;
  localparam int LINE_W = 12;
  localparam int GB_W   = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = GB_W + 4;
  localparam int XW     = LINE_W + 1;

  localparam logic [ADDR_W-1:0] A_VACT = 3'd0;
  localparam logic [ADDR_W-1:0] A_VMIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_VMAX = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLIP = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_PUSH = 3'd5;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [XW-1:0]     ext_t;

  typedef struct packed {
    line_t           vact;
    line_t           vmin_m1;
    line_t           vmax_m1;
    line_t           flip_m1;
    logic            en;
    logic            flip_en;
    logic [1:0]      fsd_m1;
    logic [GB_W-1:0] gb;
  } cfg_t;

  // guardband + (delay) + 1 extra line
  function automatic ext_t exit_len(cfg_t c);
    return ext_t'(c.gb) + ext_t'(c.fsd_m1) + ext_t'(2);
  endfunction

  function automatic ext_t flip_eff(cfg_t c);
    return c.flip_en ? ext_t'(c.flip_m1) + ext_t'(1) : ext_t'(c.vmin_m1) + ext_t'(2);
  endfunction

  function automatic ext_t first_exit(cfg_t c);
    return flip_eff(c) - exit_len(c);
  endfunction

  function automatic ext_t last_exit(cfg_t c);
    return ext_t'(c.vmax_m1) + ext_t'(1) - exit_len(c);
  endfunction
endpackage

// File: rtl/vrr_regs.sv
`timescale 1ns/1ps
module vrr_regs
  import vrr_pkg::*;
#(
  parameter line_t DEF_VACT     = line_t'(20),
  parameter line_t DEF_VTOT_M1  = line_t'(29)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              latch_now,
  input  logic              push_take,
  output cfg_t              act_cfg,
  output logic              push_pending
);
  localparam cfg_t RST_CFG = '{vact: DEF_VACT, vmin_m1: DEF_VTOT_M1,
                               vmax_m1: DEF_VTOT_M1, flip_m1: DEF_VTOT_M1,
                               en: 1'b0, flip_en: 1'b0, fsd_m1: 2'd0,
                               gb: '0};

  cfg_t armed, active;
  logic pend_q;
  logic push_wr;

  assign push_wr = wr_en && (wr_addr == A_PUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= RST_CFG;
      active <= RST_CFG;
      pend_q <= 1'b0;
    end else begin
      if (latch_now) active <= armed;
      if (wr_en) begin
        case (wr_addr)
          A_VACT: armed.vact    <= line_t'(wr_data);
          A_VMIN: armed.vmin_m1 <= line_t'(wr_data);
          A_VMAX: armed.vmax_m1 <= line_t'(wr_data);
          A_FLIP: armed.flip_m1 <= line_t'(wr_data);
          A_CTRL: begin
            armed.en      <= wr_data[0];
            armed.flip_en <= wr_data[1];
            armed.fsd_m1  <= wr_data[3:2];
            armed.gb      <= wr_data[GB_W+3:4];
          end
          default: ;
        endcase
      end
      if (push_take) pend_q <= 1'b0;
      if (push_wr) begin
        if (!wr_data[0])     pend_q <= 1'b0;
        else if (wr_data[1]) pend_q <= 1'b1;
      end
    end
  end

  assign act_cfg      = active;
  assign push_pending = pend_q;

  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    push_take && !push_wr |=> !push_pending);
  a_r8_disabled_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_wr && !wr_data[0] |=> !push_pending);
  a_r10_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_now |=> $stable(act_cfg));
endmodule

// File: rtl/vrr_window.sv
`timescale 1ns/1ps
module vrr_window
  import vrr_pkg::*;
(
  input  cfg_t cfg,
  input  ext_t nxt_line,
  input  logic pending,
  input  logic exiting,
  output ext_t elen,
  output logic take
);
  ext_t first_line, last_line;
  logic early_ok, forced;

  assign elen       = exit_len(cfg);
  assign first_line = first_exit(cfg);
  assign last_line  = last_exit(cfg);
  assign early_ok   = pending && (nxt_line >= first_line);
  assign forced     = nxt_line >= last_line;
  assign take       = cfg.en && !exiting && (early_ok || forced);
endmodule

// File: rtl/vrr_line_ctr.sv
`timescale 1ns/1ps
module vrr_line_ctr
  import vrr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  cfg_t  cfg,
  input  logic  take,
  input  ext_t  elen,
  output ext_t  nxt_line,
  output logic  exiting,
  output logic  latch_now,
  output logic  push_take,
  output line_t line,
  output logic  frame_start,
  output logic  reg_latch
);
  line_t line_q, end_q;
  logic  exit_q, fs_q, rl_q;
  logic  at_end, fixed_wrap, wrap, fixed_latch;

  assign nxt_line    = ext_t'(line_q) + ext_t'(1);
  assign at_end      = exit_q && (line_q == end_q);
  assign fixed_wrap  = !cfg.en && !exit_q && (line_q >= cfg.vmin_m1);
  assign wrap        = at_end || fixed_wrap;
  assign fixed_latch = !cfg.en && !exit_q && (nxt_line == ext_t'(cfg.vact));
  assign push_take   = tick && !wrap && take;
  assign latch_now   = tick && !wrap && (take || fixed_latch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      end_q  <= '0;
      exit_q <= 1'b0;
      fs_q   <= 1'b0;
      rl_q   <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      rl_q <= 1'b0;
      if (tick) begin
        if (wrap) begin
          line_q <= '0;
          exit_q <= 1'b0;
          fs_q   <= 1'b1;
        end else begin
          line_q <= line_t'(nxt_line);
          if (take) begin
            exit_q <= 1'b1;
            end_q  <= line_t'(nxt_line + elen - ext_t'(1));
          end
          if (take || fixed_latch) rl_q <= 1'b1;
        end
      end
    end
  end

  assign line        = line_q;
  assign exiting     = exit_q;
  assign frame_start = fs_q;
  assign reg_latch   = rl_q;

  a_r12_fs_line0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line == '0);
  a_r12_fs_latch_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, reg_latch}));
  a_r4_end_within_vmax: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_q) |-> ext_t'(end_q) <= ext_t'($past(cfg.vmax_m1)));
  a_r3_end_past_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_q) |-> ext_t'(end_q) + ext_t'(1) >= $past(flip_eff(cfg)));
endmodule

// File: rtl/vrr_vtiming.sv
`timescale 1ns/1ps
module vrr_vtiming
  import vrr_pkg::*;
#(
  parameter line_t DEF_VACT    = line_t'(20),
  parameter line_t DEF_VTOT_M1 = line_t'(29)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] line,
  output logic              vblank,
  output logic              frame_start,
  output logic              reg_latch,
  output logic              push_pending
);
  cfg_t act_cfg;
  ext_t nxt_line, elen;
  logic exiting, take, latch_now, push_take;

  vrr_regs #(.DEF_VACT(DEF_VACT), .DEF_VTOT_M1(DEF_VTOT_M1)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch_now(latch_now), .push_take(push_take),
    .act_cfg(act_cfg), .push_pending(push_pending));

  vrr_window u_win (
    .cfg(act_cfg), .nxt_line(nxt_line), .pending(push_pending),
    .exiting(exiting), .elen(elen), .take(take));

  vrr_line_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .cfg(act_cfg),
    .take(take), .elen(elen), .nxt_line(nxt_line), .exiting(exiting),
    .latch_now(latch_now), .push_take(push_take), .line(line),
    .frame_start(frame_start), .reg_latch(reg_latch));

  assign vblank = line >= act_cfg.vact;

  a_r2_fs_active: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !vblank);
  a_r5_latch_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    reg_latch |-> $past(line_tick));
endmodule

// File: tb/sim_vrr_vtiming.sv
`timescale 1ns/1ps
module sim_vrr_vtiming;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] line;
  logic        vblank, frame_start, reg_latch, push_pending;

  int total = 0, failed = 0;
  int div = 0;
  int m_line = 0, m_end = 0, m_exit = 0, m_pend = 0, m_fs = 0, m_rl = 0;
  int a[8], b[8];
  int e, flip, first, last, nxt, lat;
  int prev_line = 0, last_len = 0, nframes = 0, latch_line = -1;
  bit done = 0;

  vrr_vtiming u0 (.clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .line(line),
    .vblank(vblank), .frame_start(frame_start), .reg_latch(reg_latch),
    .push_pending(push_pending));

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  // line strobe every 4 clocks
  always @(negedge clk) begin
    if (!rst_n) begin div = 0; line_tick = 1'b0; end
    else begin line_tick = (div == 3); div = (div + 1) % 4; end
  end

  // reference model: index 0 active lines,1 vmin-1,2 vmax-1,3 flip-1,4 en,5 flip en,6 delay-1,7 guardband
  always @(posedge clk) begin
    m_fs = 0; m_rl = 0;
    if (!rst_n) begin
      m_line = 0; m_end = 0; m_exit = 0; m_pend = 0;
      a = '{20, 29, 29, 29, 0, 0, 0, 0};
      b = a;
    end else begin
      if (line_tick) begin
        lat = 0;
        e = a[7] + a[6] + 2;
        flip = a[5] ? a[3] + 1 : a[1] + 2;
        first = flip - e;
        last = a[2] + 1 - e;
        if (m_exit && m_line == m_end) begin m_line = 0; m_exit = 0; m_fs = 1; end
        else if (!a[4] && !m_exit && m_line >= a[1]) begin m_line = 0; m_fs = 1; end
        else begin
          nxt = m_line + 1;
          m_line = nxt;
          if (a[4]) begin
            if (!m_exit && ((m_pend && nxt >= first) || nxt >= last)) begin
              m_exit = 1; m_end = nxt + e - 1; lat = 1; m_pend = 0;
            end
          end else if (!m_exit && nxt == a[0]) lat = 1;
        end
        if (lat) begin m_rl = 1; a = b; end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: b[0] = wr_data;
          3'd1: b[1] = wr_data;
          3'd2: b[2] = wr_data;
          3'd3: b[3] = wr_data;
          3'd4: begin b[4] = wr_data[0]; b[5] = wr_data[1]; b[6] = wr_data[3:2]; b[7] = wr_data[11:4]; end
          3'd5: begin if (!wr_data[0]) m_pend = 0; else if (wr_data[1]) m_pend = 1; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and frame monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "line", int'(line), m_line);
      chk("R2", "vblank", int'(vblank), int'(m_line >= a[0]));
      chk("R12", "frame_start", int'(frame_start), m_fs);
      chk("R10", "reg_latch", int'(reg_latch), m_rl);
      chk("R6", "push_pending", int'(push_pending), m_pend);
      if (frame_start) begin last_len = prev_line + 1; nframes++; end
      if (reg_latch) latch_line = int'(line);
      prev_line = int'(line);
    end
  end

  task automatic wr(input int ad, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(ad); wr_data = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic next_frame();
    int n = nframes;
    do @(posedge clk); while (nframes == n);
  endtask

  task automatic wait_line(input int k);
    do @(negedge clk); while (int'(line) != k);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        done = 1;
        total++; failed++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        summary();
      end
    join_none
    repeat (3) @(negedge clk);
    chk("R1", "reset line", int'(line), 0);
    chk("R1", "reset frame_start", int'(frame_start), 0);
    chk("R1", "reset reg_latch", int'(reg_latch), 0);
    chk("R1", "reset pending", int'(push_pending), 0);
    chk("R1", "reset vblank", int'(vblank), 0);
    rst_n = 1'b1;
    next_frame(); next_frame();
    chk("R1", "default frame length", last_len, 30);
    chk("R7", "fixed latch line", latch_line, 20);
    // variable mode: vmax 60, flip 33, delay 2, guardband 3 -> exit length 6
    wr(0, 20); wr(1, 29); wr(2, 59); wr(3, 32); wr(4, 12'h037); wr(5, 1);
    next_frame(); next_frame();
    chk("R4", "no-push length", last_len, 60);
    chk("R4", "forced exit line", latch_line, 54);
    wait_line(10); wr(5, 3);
    @(negedge clk);
    chk("R6", "pending readback", int'(push_pending), 1);
    next_frame();
    chk("R3", "early-push length", last_len, 33);
    chk("R3", "early exit line", latch_line, 27);
    chk("R6", "pending cleared", int'(push_pending), 0);
    wait_line(40); wr(5, 3);
    next_frame();
    chk("R5", "mid-window length", last_len, 47);
    chk("R5", "mid-window latch line", latch_line, 41);
    wait_line(10); wr(5, 2);
    @(negedge clk);
    chk("R8", "disabled push pending", int'(push_pending), 0);
    next_frame();
    chk("R8", "disabled push length", last_len, 60);
    wait_line(10); wr(2, 49);
    next_frame();
    chk("R10", "old vmax frame", last_len, 60);
    wait_line(10); wr(4, 12'h035);
    next_frame();
    chk("R10", "new vmax frame", last_len, 50);
    wait_line(5); wr(5, 3);
    wait_line(10); wr(4, 12'h057);
    next_frame();
    chk("R9", "flip from vmin", last_len, 31);
    wait_line(40); wr(5, 3);
    next_frame();
    chk("R11", "guardband 5 length", last_len, 49);
    wait_line(10); wr(4, 0);
    next_frame();
    chk("R11", "forced exit gb5", last_len, 50);
    next_frame();
    chk("R7", "fixed length", last_len, 30);
    chk("R7", "fixed latch line", latch_line, 20);
    done = 1;
    summary();
  end
endmodule